// File: doc/BRIEF.md
# Windowed 32-to-64-bit Address Translator

This block lets a master that only produces 32-bit addresses reach any region of a 64-bit host address space. It decodes two fixed 8 MiB windows in the 32-bit space. A request that lands in a window is passed upstream with a 64-bit address. That address is the window's programmable host base plus the request's offset inside the window. A request that lands in neither window is not passed on and gets a decode-error response instead.

The host bases are held in four 32-bit registers, one upper and one lower word per window. They are reached through a 32-bit AXI4-Lite style register port. Software can move a window anywhere in the wide space while the system runs. A single registered stage sits between the request input and the two result outputs. Each request is translated when it is accepted, so a later register write cannot change a request that is already held in the stage.

Top module: `addr_window_xlat`

## Requirements
- R1: A request address in 0x80800000..0x80FFFFFF (window 0) is forwarded with host address = {window 0 upper register, window 0 lower register} + request address bits [22:0].
- R2: A request address in 0x80000000..0x807FFFFF (window 1) is forwarded with host address = {window 1 upper register, window 1 lower register} + request address bits [22:0].
- R3: After reset, window 0 translates to 0x00000000_A0000000 and window 1 translates to 0x00000000_C0000000. The registers read back 0x00000000, 0xA0000000, 0x00000000 and 0xC0000000.
- R4: The register byte offsets are: window 0 upper at 0x208 and lower at 0x20C; window 1 upper at 0x210 and lower at 0x214. A full-strobe write to an upper register is read back unchanged and supplies host address bits [63:32].
- R5: Bits [22:0] of each lower register always read as zero. Write data in those bits is discarded.
- R6: Write strobe bit n (covering data bits [8n+7:8n]) selects which bytes of the addressed register are updated. Bytes whose strobe is 0 keep their old value.
- R7: Reads of any other register offset return 0. Writes to any other offset change no register. Both return response code 0 (OKAY).
- R8: A request address outside both windows is not forwarded. It produces an error result with response code 2'b11 (DECERR), and that result is held until taken.
- R9: A request is translated with the register values in force when it is accepted. A request held in the stage keeps its address across a register write. Requests accepted after the write response appear use the new value.
- R10: A held result keeps its valid and address stable until its ready is seen. While a result is held and not taken, the request input is not ready.
- R11: A register write is accepted only when the address and data valids are both high. Each accepted write produces exactly one write response on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | 32-bit request address |
| req_write | input | 1 | Request direction, passed through |
| fwd_valid | output | 1 | Translated request valid |
| fwd_ready | input | 1 | Upstream accepts translated request |
| fwd_addr | output | 64 | Translated host address |
| fwd_write | output | 1 | Direction of translated request |
| err_valid | output | 1 | Decode-error result valid |
| err_ready | input | 1 | Error result taken |
| err_resp | output | 2 | Error response code (2'b11) |
| csr_awvalid | input | 1 | Register write address valid |
| csr_awready | output | 1 | Register write address ready |
| csr_awaddr | input | 12 | Register write byte offset |
| csr_wvalid | input | 1 | Register write data valid |
| csr_wready | output | 1 | Register write data ready |
| csr_wdata | input | 32 | Register write data |
| csr_wstrb | input | 4 | Register write byte strobes |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response taken |
| csr_bresp | output | 2 | Write response code |
| csr_arvalid | input | 1 | Register read address valid |
| csr_arready | output | 1 | Register read address ready |
| csr_araddr | input | 12 | Register read byte offset |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data taken |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response code |

## Verification
The bench probes the window edges: 0x807FFFFF, 0x80800000, 0x80FFFFFF and 0x81000000. A compare on the wrong number of address bits, or on the wrong base, sends one of these to the wrong window or wrongly flags a decode error. Lower-register writes carry nonzero data in bits [22:0]. A missing mask would leak those bits into the read-back value and OR them into every translated offset. Partial-strobe writes would show up a design that ignores strobes, because the untouched bytes would be overwritten. One request is held in the stage while the translation registers are rewritten. A design that translates at the output rather than at acceptance would change the held address.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

   localparam int NWIN    = 2;
   localparam int HADDR_W = 64;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01,
      RESP_SLVERR = 2'b10,
      RESP_DECERR = 2'b11
   } axi_resp_e;

   // byte-lane merge of a 32-bit word under a 4-bit strobe
   function automatic logic [31:0] strb_merge(input logic [31:0] old_w,
                                              input logic [31:0] new_w,
                                              input logic [3:0]  strb);
      logic [31:0] r;
      r = old_w;
      for (int b = 0; b < 4; b++) begin
         if (strb[b]) r[8*b +: 8] = new_w[8*b +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/xlat_win_regs.sv
`timescale 1ns/1ps
module xlat_win_regs #(
   parameter int          WIN_BITS = 23,
   parameter logic [63:0] RST_HOST = 64'h0000_0000_A000_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hi,
   input  logic        wr_lo,
   input  logic [31:0] wdata,
   input  logic [3:0]  wstrb,
   output logic [31:0] hi_q,
   output logic [31:0] lo_q
);
   import xlat_pkg::*;

   localparam logic [31:0] LO_KEEP = {{(32-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= RST_HOST[63:32];
         lo_q <= RST_HOST[31:0] & LO_KEEP;
      end else begin
         if (wr_hi) hi_q <= strb_merge(hi_q, wdata, wstrb);
         if (wr_lo) lo_q <= strb_merge(lo_q, wdata, wstrb) & LO_KEEP;
      end
   end

   AST_LO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lo_q[WIN_BITS-1:0] == '0);                                          // R5
   AST_HI_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && wstrb == 4'hF) |=> hi_q == $past(wdata));                 // R4

endmodule

// File: rtl/xlat_csr.sv
`timescale 1ns/1ps
module xlat_csr #(
   parameter int                               CSR_AW   = 12,
   parameter int                               WIN_BITS = 23,
   parameter int                               REG_BASE = 'h208,
   parameter logic [xlat_pkg::NWIN*64-1:0]     WIN_RST  = {64'h0000_0000_C000_0000, 64'h0000_0000_A000_0000}
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          awvalid,
   output logic                          awready,
   input  logic [CSR_AW-1:0]             awaddr,
   input  logic                          wvalid,
   output logic                          wready,
   input  logic [31:0]                   wdata,
   input  logic [3:0]                    wstrb,
   output logic                          bvalid,
   input  logic                          bready,
   output logic [1:0]                    bresp,
   input  logic                          arvalid,
   output logic                          arready,
   input  logic [CSR_AW-1:0]             araddr,
   output logic                          rvalid,
   input  logic                          rready,
   output logic [31:0]                   rdata,
   output logic [1:0]                    rresp,
   output logic [xlat_pkg::NWIN*32-1:0]  base_hi,
   output logic [xlat_pkg::NWIN*32-1:0]  base_lo
);
   import xlat_pkg::*;

   logic            wr_go, rd_go;
   logic [NWIN-1:0] wr_hi, wr_lo;
   logic [31:0]     rd_val;

   assign wr_go   = awvalid & wvalid & ~bvalid;
   assign awready = wr_go;
   assign wready  = wr_go;
   assign arready = ~rvalid;
   assign rd_go   = arvalid & arready;
   assign bresp   = RESP_OKAY;
   assign rresp   = RESP_OKAY;

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      localparam logic [CSR_AW-1:0] HI_OFS = CSR_AW'(REG_BASE + 8*i);
      localparam logic [CSR_AW-1:0] LO_OFS = CSR_AW'(REG_BASE + 8*i + 4);

      assign wr_hi[i] = wr_go & (awaddr == HI_OFS);
      assign wr_lo[i] = wr_go & (awaddr == LO_OFS);

      xlat_win_regs #(
         .WIN_BITS (WIN_BITS),
         .RST_HOST (WIN_RST[64*i +: 64])
      ) u_regs (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_hi (wr_hi[i]),
         .wr_lo (wr_lo[i]),
         .wdata (wdata),
         .wstrb (wstrb),
         .hi_q  (base_hi[32*i +: 32]),
         .lo_q  (base_lo[32*i +: 32])
      );
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (araddr == CSR_AW'(REG_BASE + 8*i))     rd_val = base_hi[32*i +: 32];
         if (araddr == CSR_AW'(REG_BASE + 8*i + 4)) rd_val = base_lo[32*i +: 32];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bvalid <= 1'b0;
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         if (wr_go)       bvalid <= 1'b1;
         else if (bready) bvalid <= 1'b0;
         if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_val;
         end else if (rready) begin
            rvalid <= 1'b0;
         end
      end
   end

   AST_B_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && wvalid && !bvalid) |=> bvalid);                          // R11
   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid);                                     // R11
   AST_NO_HALF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bvalid && !(awvalid && wvalid)) |=> !bvalid);                      // R11
   AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && !rready) |=> (rvalid && $stable(rdata)));                 // R7

endmodule

// File: rtl/xlat_decode.sv
`timescale 1ns/1ps
module xlat_decode #(
   parameter int                           WIN_BITS  = 23,
   parameter logic [xlat_pkg::NWIN*32-1:0] WIN_BASES = {32'h8000_0000, 32'h8080_0000}
) (
   input  logic [31:0]                   addr,
   input  logic [xlat_pkg::NWIN*32-1:0]  base_hi,
   input  logic [xlat_pkg::NWIN*32-1:0]  base_lo,
   output logic                          hit_any,
   output logic [xlat_pkg::HADDR_W-1:0]  haddr
);
   import xlat_pkg::*;

   localparam int TAG_W = 32 - WIN_BITS;

   logic [NWIN-1:0]  hit;
   logic [31:0]      offset;

   assign offset = {{TAG_W{1'b0}}, addr[WIN_BITS-1:0]};

   for (genvar i = 0; i < NWIN; i++) begin : g_cmp
      localparam logic [TAG_W-1:0] TAG = WIN_BASES[32*i + WIN_BITS +: TAG_W];
      assign hit[i] = (addr[31:WIN_BITS] == TAG);
   end

   assign hit_any = |hit;

   always_comb begin
      haddr = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (hit[i]) haddr = haddr | {base_hi[32*i +: 32], base_lo[32*i +: 32] | offset};
      end
   end

endmodule

// File: rtl/xlat_req_stage.sv
`timescale 1ns/1ps
module xlat_req_stage (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic                          req_write,
   input  logic                          hit_any,
   input  logic [xlat_pkg::HADDR_W-1:0]  haddr,
   output logic                          fwd_valid,
   input  logic                          fwd_ready,
   output logic [xlat_pkg::HADDR_W-1:0]  fwd_addr,
   output logic                          fwd_write,
   output logic                          err_valid,
   input  logic                          err_ready,
   output xlat_pkg::axi_resp_e           err_resp
);
   import xlat_pkg::*;

   logic               full_q, is_err_q, write_q;
   logic [HADDR_W-1:0] haddr_q;
   logic               drain, accept;

   assign drain     = full_q & ((~is_err_q & fwd_ready) | (is_err_q & err_ready));
   assign req_ready = ~full_q | drain;
   assign accept    = req_valid & req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         is_err_q <= 1'b0;
         write_q  <= 1'b0;
         haddr_q  <= '0;
      end else if (accept) begin
         full_q   <= 1'b1;
         is_err_q <= ~hit_any;
         write_q  <= req_write;
         haddr_q  <= hit_any ? haddr : '0;
      end else if (drain) begin
         full_q   <= 1'b0;
      end
   end

   assign fwd_valid = full_q & ~is_err_q;
   assign err_valid = full_q & is_err_q;
   assign fwd_addr  = haddr_q;
   assign fwd_write = write_q;
   assign err_resp  = is_err_q ? RESP_DECERR : RESP_OKAY;

   AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr)));     // R9
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_valid && !err_ready) |=> err_valid);                            // R8
   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_valid, err_valid}));                                   // R8
   AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid && !fwd_ready) |-> !req_ready);                           // R10

endmodule

// File: rtl/addr_window_xlat.sv
`timescale 1ns/1ps
module addr_window_xlat #(
   parameter int                           CSR_AW    = 12,
   parameter int                           WIN_BITS  = 23,
   parameter int                           REG_BASE  = 'h208,
   parameter logic [xlat_pkg::NWIN*32-1:0] WIN_BASES = {32'h8000_0000, 32'h8080_0000},
   parameter logic [xlat_pkg::NWIN*64-1:0] WIN_RST   = {64'h0000_0000_C000_0000, 64'h0000_0000_A000_0000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [31:0]       req_addr,
   input  logic              req_write,
   output logic              fwd_valid,
   input  logic              fwd_ready,
   output logic [63:0]       fwd_addr,
   output logic              fwd_write,
   output logic              err_valid,
   input  logic              err_ready,
   output logic [1:0]        err_resp,
   input  logic              csr_awvalid,
   output logic              csr_awready,
   input  logic [CSR_AW-1:0] csr_awaddr,
   input  logic              csr_wvalid,
   output logic              csr_wready,
   input  logic [31:0]       csr_wdata,
   input  logic [3:0]        csr_wstrb,
   output logic              csr_bvalid,
   input  logic              csr_bready,
   output logic [1:0]        csr_bresp,
   input  logic              csr_arvalid,
   output logic              csr_arready,
   input  logic [CSR_AW-1:0] csr_araddr,
   output logic              csr_rvalid,
   input  logic              csr_rready,
   output logic [31:0]       csr_rdata,
   output logic [1:0]        csr_rresp
);
   import xlat_pkg::*;

   localparam int TAG_W = 32 - WIN_BITS;

   // elaboration-time parameter checks
   if (WIN_BITS < 12 || WIN_BITS > 30) begin : g_bad_win_bits
      $error("WIN_BITS out of range");
   end
   if ((REG_BASE % 8) != 0 || (REG_BASE + 8*NWIN) > (1 << CSR_AW)) begin : g_bad_reg_base
      $error("REG_BASE misaligned or outside the register space");
   end
   for (genvar i = 0; i < NWIN; i++) begin : g_chk
      if (WIN_BASES[32*i +: WIN_BITS] != '0) begin : g_bad_base
         $error("window base not aligned to window size");
      end
      if (WIN_RST[64*i +: WIN_BITS] != '0) begin : g_bad_rst
         $error("reset translation not aligned to window size");
      end
   end
   if (WIN_BASES[WIN_BITS +: TAG_W] == WIN_BASES[32 + WIN_BITS +: TAG_W]) begin : g_overlap
      $error("windows overlap");
   end

   logic [NWIN*32-1:0] base_hi, base_lo;
   logic               hit_any;
   logic [HADDR_W-1:0] haddr;
   axi_resp_e          err_code;

   xlat_csr #(
      .CSR_AW   (CSR_AW),
      .WIN_BITS (WIN_BITS),
      .REG_BASE (REG_BASE),
      .WIN_RST  (WIN_RST)
   ) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .awvalid (csr_awvalid),
      .awready (csr_awready),
      .awaddr  (csr_awaddr),
      .wvalid  (csr_wvalid),
      .wready  (csr_wready),
      .wdata   (csr_wdata),
      .wstrb   (csr_wstrb),
      .bvalid  (csr_bvalid),
      .bready  (csr_bready),
      .bresp   (csr_bresp),
      .arvalid (csr_arvalid),
      .arready (csr_arready),
      .araddr  (csr_araddr),
      .rvalid  (csr_rvalid),
      .rready  (csr_rready),
      .rdata   (csr_rdata),
      .rresp   (csr_rresp),
      .base_hi (base_hi),
      .base_lo (base_lo)
   );

   xlat_decode #(
      .WIN_BITS  (WIN_BITS),
      .WIN_BASES (WIN_BASES)
   ) u_dec (
      .addr    (req_addr),
      .base_hi (base_hi),
      .base_lo (base_lo),
      .hit_any (hit_any),
      .haddr   (haddr)
   );

   xlat_req_stage u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_write (req_write),
      .hit_any   (hit_any),
      .haddr     (haddr),
      .fwd_valid (fwd_valid),
      .fwd_ready (fwd_ready),
      .fwd_addr  (fwd_addr),
      .fwd_write (fwd_write),
      .err_valid (err_valid),
      .err_ready (err_ready),
      .err_resp  (err_code)
   );

   assign err_resp = err_code;

   AST_DECERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> err_resp == 2'b11);                                    // R8
   AST_FWD_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit_any) |=>
         fwd_addr[WIN_BITS-1:0] == $past(req_addr[WIN_BITS-1:0]));         // R1

endmodule

// File: tb/addr_window_xlat_test.sv
`timescale 1ns/1ps
module addr_window_xlat_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, fwd_ready = 0, err_ready = 0;
   logic [31:0] req_addr = '0;
   logic        req_ready, fwd_valid, fwd_write, err_valid;
   logic [63:0] fwd_addr;
   logic [1:0]  err_resp;
   logic        csr_awvalid = 0, csr_wvalid = 0, csr_bready = 0, csr_arvalid = 0, csr_rready = 0;
   logic [11:0] csr_awaddr = '0, csr_araddr = '0;
   logic [31:0] csr_wdata = '0;
   logic [3:0]  csr_wstrb = '0;
   logic        csr_awready, csr_wready, csr_bvalid, csr_arready, csr_rvalid;
   logic [1:0]  csr_bresp, csr_rresp;
   logic [31:0] csr_rdata;

   int  n_cmp = 0, n_bad = 0;
   bit  done = 0;

   always #5 clk = ~clk;

   addr_window_xlat uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr), .fwd_write(fwd_write),
      .err_valid(err_valid), .err_ready(err_ready), .err_resp(err_resp),
      .csr_awvalid(csr_awvalid), .csr_awready(csr_awready), .csr_awaddr(csr_awaddr),
      .csr_wvalid(csr_wvalid), .csr_wready(csr_wready), .csr_wdata(csr_wdata), .csr_wstrb(csr_wstrb),
      .csr_bvalid(csr_bvalid), .csr_bready(csr_bready), .csr_bresp(csr_bresp),
      .csr_arvalid(csr_arvalid), .csr_arready(csr_arready), .csr_araddr(csr_araddr),
      .csr_rvalid(csr_rvalid), .csr_rready(csr_rready), .csr_rdata(csr_rdata), .csr_rresp(csr_rresp)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic csr_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      csr_awvalid = 1; csr_wvalid = 1; csr_awaddr = a; csr_wdata = d; csr_wstrb = s; csr_bready = 1;
      while (!csr_awready) @(negedge clk);
      @(negedge clk);
      csr_awvalid = 0; csr_wvalid = 0;
      chk("R11 write response after accept", 64'(csr_bvalid), 64'd1);
      chk("R7 write response OKAY", 64'(csr_bresp), 64'd0);
      @(negedge clk);
   endtask

   task automatic csr_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_arvalid = 1; csr_araddr = a; csr_rready = 1;
      while (!csr_arready) @(negedge clk);
      @(negedge clk);
      csr_arvalid = 0;
      chk("R7 read valid", 64'(csr_rvalid), 64'd1);
      chk("R7 read response OKAY", 64'(csr_rresp), 64'd0);
      d = csr_rdata;
      @(negedge clk);
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      csr_rd(a, d);
      chk(tag, 64'(d), 64'(exp));
   endtask

   // issues a request and leaves the result held in the stage
   task automatic send_req(input logic [31:0] a, input logic w);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_write = w;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic drain();
      @(negedge clk);
      fwd_ready = 1; err_ready = 1;
      @(negedge clk);
      fwd_ready = 0; err_ready = 0;
   endtask

   task automatic expect_fwd(input string tag, input logic [31:0] a, input logic [63:0] exp);
      send_req(a, 1'b1);
      chk({tag, " valid"}, 64'(fwd_valid), 64'd1);
      chk({tag, " no error"}, 64'(err_valid), 64'd0);
      chk({tag, " address"}, fwd_addr, exp);
      chk({tag, " direction"}, 64'(fwd_write), 64'd1);
      drain();
   endtask

   task automatic expect_err(input string tag, input logic [31:0] a);
      send_req(a, 1'b0);
      chk({tag, " not forwarded"}, 64'(fwd_valid), 64'd0);
      chk({tag, " error valid"}, 64'(err_valid), 64'd1);
      chk({tag, " DECERR"}, 64'(err_resp), 64'd3);
      drain();
   endtask

   task automatic t_reset();
      chk("R10 reset no forward", 64'(fwd_valid), 64'd0);
      chk("R8 reset no error", 64'(err_valid), 64'd0);
      chk("R11 reset no bvalid", 64'(csr_bvalid), 64'd0);
      chk("R10 reset ready", 64'(req_ready), 64'd1);
      rd_chk("R3 R4 win0 upper reset", 12'h208, 32'h0000_0000);
      rd_chk("R3 R4 win0 lower reset", 12'h20C, 32'hA000_0000);
      rd_chk("R3 R4 win1 upper reset", 12'h210, 32'h0000_0000);
      rd_chk("R3 R4 win1 lower reset", 12'h214, 32'hC000_0000);
      expect_fwd("R3 R1 win0 reset map", 32'h8080_0000, 64'h0000_0000_A000_0000);
      expect_fwd("R3 R2 win1 reset map", 32'h8000_0010, 64'h0000_0000_C000_0010);
   endtask

   task automatic t_bounds();
      expect_fwd("R2 win1 top edge", 32'h807F_FFFF, 64'h0000_0000_C07F_FFFF);
      expect_fwd("R1 win0 top edge", 32'h80FF_FFFF, 64'h0000_0000_A07F_FFFF);
      expect_err("R8 above win0", 32'h8100_0000);
      expect_err("R8 below win1", 32'h7FFF_FFFF);
      expect_err("R8 zero address", 32'h0000_0000);
   endtask

   task automatic t_program();
      csr_wr(12'h208, 32'hDEAD_BEEF, 4'hF);
      csr_wr(12'h20C, 32'h1234_5678, 4'hF);
      rd_chk("R4 win0 upper readback", 12'h208, 32'hDEAD_BEEF);
      rd_chk("R5 win0 lower masked", 12'h20C, 32'h1200_0000);
      expect_fwd("R1 R4 R5 win0 programmed", 32'h8081_2345, 64'hDEAD_BEEF_1201_2345);
      csr_wr(12'h210, 32'h0000_0001, 4'hF);
      csr_wr(12'h214, 32'h807F_FFFF, 4'hF);
      rd_chk("R5 win1 lower masked", 12'h214, 32'h8000_0000);
      expect_fwd("R2 R4 win1 programmed", 32'h8000_0123, 64'h0000_0001_8000_0123);
   endtask

   task automatic t_strobe();
      csr_wr(12'h214, 32'hFFFF_FFFF, 4'b1000);
      rd_chk("R6 top byte only", 12'h214, 32'hFF00_0000);
      csr_wr(12'h210, 32'h1122_3344, 4'b0001);
      rd_chk("R6 low byte only", 12'h210, 32'h0000_0044);
      csr_wr(12'h208, 32'h5566_7788, 4'b0000);
      rd_chk("R6 empty strobe", 12'h208, 32'hDEAD_BEEF);
   endtask

   task automatic t_unused();
      csr_wr(12'h200, 32'hFFFF_FFFF, 4'hF);
      csr_wr(12'h218, 32'hFFFF_FFFF, 4'hF);
      rd_chk("R7 unused 0x200 reads zero", 12'h200, 32'h0);
      rd_chk("R7 unused 0x218 reads zero", 12'h218, 32'h0);
      rd_chk("R7 win0 upper untouched", 12'h208, 32'hDEAD_BEEF);
      rd_chk("R7 win0 lower untouched", 12'h20C, 32'h1200_0000);
      rd_chk("R7 win1 upper untouched", 12'h210, 32'h0000_0044);
      rd_chk("R7 win1 lower untouched", 12'h214, 32'hFF00_0000);
   endtask

   task automatic t_inflight();
      send_req(32'h8000_0004, 1'b0);
      chk("R9 held address before rewrite", fwd_addr, 64'h0000_0044_FF00_0004);
      chk("R9 direction held", 64'(fwd_write), 64'd0);
      @(negedge clk);
      req_valid = 1; req_addr = 32'h8080_0000;
      chk("R10 input stalled while held", 64'(req_ready), 64'd0);
      req_valid = 0;
      csr_wr(12'h214, 32'h4000_0000, 4'hF);
      chk("R9 held address after rewrite", fwd_addr, 64'h0000_0044_FF00_0004);
      chk("R10 still valid while not taken", 64'(fwd_valid), 64'd1);
      drain();
      chk("R10 released after ready", 64'(fwd_valid), 64'd0);
      expect_fwd("R9 new request uses new base", 32'h8000_0004, 64'h0000_0044_4000_0004);
   endtask

   task automatic t_err_hold();
      send_req(32'h9000_0000, 1'b1);
      repeat (3) @(negedge clk);
      chk("R8 error held without ready", 64'(err_valid), 64'd1);
      chk("R8 error held code", 64'(err_resp), 64'd3);
      chk("R10 input stalled on error", 64'(req_ready), 64'd0);
      drain();
      chk("R8 error released", 64'(err_valid), 64'd0);
   endtask

   task automatic t_half_write();
      @(negedge clk);
      csr_awvalid = 1; csr_awaddr = 12'h208; csr_wvalid = 0; csr_bready = 1;
      chk("R11 no accept without data", 64'(csr_awready), 64'd0);
      @(negedge clk);
      chk("R11 no response without data", 64'(csr_bvalid), 64'd0);
      csr_awvalid = 0;
      rd_chk("R11 register unchanged", 12'h208, 32'hDEAD_BEEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bounds();
      t_program();
      t_strobe();
      t_unused();
      t_inflight();
      t_err_hold();
      t_half_write();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule